// File: doc/BRIEF.md
# Sequenced Vector Functional Unit

This unit executes one wide vector instruction at a time on a datapath much narrower than the vector. An instruction gives an operation, a destination base register, two source base registers and an element count. The unit walks the element index upward, handling `LANES` elements per cycle (default one). For each element it reads both sources from an external register file, computes the result and writes it back. One instruction therefore keeps the unit occupied for about one cycle per element, plus a fixed pipeline latency. The register file has two synchronous read ports and one write port per lane, and read data returns one cycle after the address.

Elements are 16-bit signed fixed point with 12 fraction bits, so 1.0 is `0x1000`.
- Add and multiply saturate.
- Sigmoid and tanh come from a 256-entry table per function. The table is addressed by the upper eight bits of source A and has a registered output.

The control is a four-state machine:
- IDLE: waiting for an instruction.
- ISSUE: one cycle per group of `LANES` elements, driving read addresses.
- DRAIN: waiting while the last reads pass through the two pipeline stages.
- FINISH: one cycle that signals completion.

The transitions are:
- IDLE or FINISH go to ISSUE on an accepted instruction with a nonzero count.
- IDLE or FINISH go to FINISH on an accepted zero-count instruction.
- IDLE or FINISH go to IDLE when no instruction arrives.
- ISSUE goes to DRAIN after its last group.
- DRAIN goes to FINISH when the last group is written.

Top module: `tsimd_vfu`

## Requirements
- R1: An instruction presented on `issue_valid` while `busy` is low is accepted at that clock edge; for a nonzero count, `busy` is high in the following cycle.
- R2: While `busy` is high, `issue_valid` is ignored: the running instruction is unchanged and the ignored instruction writes nothing.
- R3: Opcode 0 is add. Each element is the sum of A and B, saturating to `0x7FFF` or `0x8000`.
- R4: Opcode 1 is multiply. Each element is the full product of A and B, arithmetically shifted right by 12 (rounding toward minus infinity), saturating to `0x7FFF` or `0x8000`.
- R5: Opcode 2 is sigmoid. Let k be the signed value of source A bits 15:8. The result is 2048 + 64·k, clamped to the range 0 to 4096. Source B and bits 7:0 of A have no effect.
- R6: Opcode 3 is tanh. Let k be the signed value of source A bits 15:8. The result is 256·k, clamped to the range −4096 to 4096. Source B has no effect.
- R7: Element i reads registers `src_a+i` and `src_b+i` and is written to `dst+i`. Writes occur in ascending index order, one per lane per cycle.
- R8: For a count n > 0, `busy` is high for exactly ceil(n/LANES)+2 cycles. Every write happens while `busy` is high. `done` is high for one cycle, the first cycle after `busy` falls.
- R9: A count of zero performs no writes and keeps `busy` low. `done` is high in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Instruction present |
| issue_op | input | 2 | Opcode: 0 add, 1 mul, 2 sigmoid, 3 tanh |
| issue_dst | input | AW | Destination base register |
| issue_src_a | input | AW | Source A base register |
| issue_src_b | input | AW | Source B base register |
| issue_len | input | LEN_W | Element count n |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | LANES | Per-lane read enable |
| rd_a_addr | output | LANES*AW | Source A read addresses |
| rd_b_addr | output | LANES*AW | Source B read addresses |
| rd_a_data | input | LANES*DW | Source A data, one cycle after address |
| rd_b_data | input | LANES*DW | Source B data, one cycle after address |
| wr_en | output | LANES | Per-lane write enable |
| wr_addr | output | LANES*AW | Write addresses |
| wr_data | output | LANES*DW | Write data |

## Verification
Some properties are checked by assertions on every cycle:
- The instruction registers hold still while busy.
- Writes stay inside the busy window, and the write address climbs by `LANES` between consecutive writes.
- Table outputs stay within their clamped ranges.
- The saturation signs are right for add and multiply.
- A zero-length instruction finishes at once.

Only the bench scenarios can show the rest:
- The exact result values, including floor rounding and the coarse table index.
- The busy length of ceil(n/LANES)+2 cycles.
- That an instruction issued while busy leaves its destination untouched.

// File: rtl/tsimd_vfu_pkg.sv
package tsimd_vfu_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_MUL  = 2'd1,
        OP_SIG  = 2'd2,
        OP_TANH = 2'd3
    } vop_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_FINISH
    } vstate_e;

endpackage

// File: rtl/tsimd_vfu_nl_rom.sv
module tsimd_vfu_nl_rom #(
    parameter int DW     = 16,
    parameter int FRAC_W = 12,
    parameter int LUT_AW = 8
) (
    input  logic              clk,
    input  logic              sel_tanh,
    input  logic [LUT_AW-1:0] idx,
    output logic [DW-1:0]     q
);
    localparam int STEP_SH = DW - LUT_AW;   // raw weight of one index step
    localparam int ONE     = 1 << FRAC_W;

    // Hard-linear approximations, evaluated per entry; the result is a ROM.
    function automatic logic [DW-1:0] entry(input logic tsel, input logic [LUT_AW-1:0] i);
        logic signed [31:0] k;
        logic signed [31:0] v;
        k = 32'(signed'(i));
        if (tsel) begin
            v = k * (32'sd1 <<< STEP_SH);
            if (v > 32'(ONE))  v = 32'(ONE);
            if (v < -32'(ONE)) v = -32'(ONE);
        end else begin
            v = 32'(ONE / 2) + k * (32'sd1 <<< (STEP_SH - 2));
            if (v > 32'(ONE)) v = 32'(ONE);
            if (v < 0)        v = 0;
        end
        return v[DW-1:0];
    endfunction

    always_ff @(posedge clk) begin
        q <= entry(sel_tanh, idx);
    end

endmodule

// File: rtl/tsimd_vfu_lane.sv
module tsimd_vfu_lane
    import tsimd_vfu_pkg::*;
#(
    parameter int DW     = 16,
    parameter int FRAC_W = 12,
    parameter int LUT_AW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  vop_e                 op,
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic        [DW-1:0] res
);
    localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic signed [DW:0]     sum_w;
    logic signed [2*DW-1:0] prod_w;
    logic signed [2*DW-1:0] prod_sh;
    logic        [DW:0]     prod_hi;
    logic        [DW-1:0]   sum_sat;
    logic        [DW-1:0]   mul_sat;
    logic        [DW-1:0]   arith_c;
    logic        [DW-1:0]   arith_q;
    logic        [DW-1:0]   rom_q;

    always_comb begin
        sum_w   = {a[DW-1], a} + {b[DW-1], b};
        sum_sat = (sum_w[DW] != sum_w[DW-1]) ? (sum_w[DW] ? MINV : MAXV)
                                             : sum_w[DW-1:0];
        prod_w  = a * b;
        prod_sh = prod_w >>> FRAC_W;
        prod_hi = prod_sh[2*DW-1:DW-1];
        if ((prod_hi == '0) || (&prod_hi)) mul_sat = prod_sh[DW-1:0];
        else                               mul_sat = prod_sh[2*DW-1] ? MINV : MAXV;
        arith_c = (op == OP_MUL) ? mul_sat : sum_sat;
    end

    always_ff @(posedge clk) begin
        arith_q <= arith_c;
    end

    tsimd_vfu_nl_rom #(
        .DW    (DW),
        .FRAC_W(FRAC_W),
        .LUT_AW(LUT_AW)
    ) u_rom (
        .clk     (clk),
        .sel_tanh(op == OP_TANH),
        .idx     (a[DW-1 -: LUT_AW]),
        .q       (rom_q)
    );

    assign res = ((op == OP_SIG) || (op == OP_TANH)) ? rom_q : arith_q;

    AST_ADD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD && a[DW-1] == b[DW-1]) |=> (arith_q[DW-1] == $past(a[DW-1]))) // R3
        else $error("add result sign wrong");

    AST_MUL_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MUL && a != '0 && b != '0 && a[DW-1] != b[DW-1]) |=> arith_q[DW-1]) // R4
        else $error("mul result sign wrong");

endmodule

// File: rtl/tsimd_vfu_seq.sv
module tsimd_vfu_seq
    import tsimd_vfu_pkg::*;
#(
    parameter int LANES = 1,
    parameter int AW    = 8,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [1:0]       issue_op,
    input  logic [AW-1:0]    issue_dst,
    input  logic [AW-1:0]    issue_src_a,
    input  logic [AW-1:0]    issue_src_b,
    input  logic [LEN_W-1:0] issue_len,
    output logic             busy,
    output logic             done,
    output vop_e             op_o,
    output logic [LANES-1:0] rd_en,
    output logic [AW-1:0]    rd_a_base,
    output logic [AW-1:0]    rd_b_base,
    output logic [LANES-1:0] wr_en,
    output logic [AW-1:0]    wr_base
);
    localparam int IDX_W = LEN_W + 2;

    vstate_e          state, state_nx;
    logic [IDX_W-1:0] idx_q, idx_next, len_ext;
    logic [LEN_W-1:0] len_q;
    logic [AW-1:0]    dst_q, srca_q, srcb_q;
    vop_e             op_q;
    logic             accept, last_issue;
    logic [LANES-1:0] lane_live;
    logic             s1_valid, s1_last, s2_valid, s2_last;
    logic [LANES-1:0] s1_mask, s2_mask;
    logic [IDX_W-1:0] s1_idx, s2_idx;

    assign len_ext    = IDX_W'(len_q);
    assign idx_next   = idx_q + IDX_W'(LANES);
    assign last_issue = (idx_next >= len_ext);
    assign accept     = issue_valid && !busy;

    for (genvar j = 0; j < LANES; j++) begin : g_live
        assign lane_live[j] = (idx_q + IDX_W'(j)) < len_ext;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_FINISH: begin
                if (accept) state_nx = (issue_len == '0) ? ST_FINISH : ST_ISSUE;
                else        state_nx = ST_IDLE;
            end
            ST_ISSUE: if (last_issue)           state_nx = ST_DRAIN;
            ST_DRAIN: if (s2_valid && s2_last)  state_nx = ST_FINISH;
            default:                            state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        busy      = (state == ST_ISSUE) || (state == ST_DRAIN);
        done      = (state == ST_FINISH);
        op_o      = op_q;
        rd_en     = (state == ST_ISSUE) ? lane_live : '0;
        rd_a_base = srca_q + AW'(idx_q);
        rd_b_base = srcb_q + AW'(idx_q);
        wr_en     = s2_valid ? s2_mask : '0;
        wr_base   = dst_q + AW'(s2_idx);
    end

    // instruction registers and pipeline control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            len_q    <= '0;
            dst_q    <= '0;
            srca_q   <= '0;
            srcb_q   <= '0;
            op_q     <= OP_ADD;
            s1_valid <= 1'b0;
            s1_last  <= 1'b0;
            s1_mask  <= '0;
            s1_idx   <= '0;
            s2_valid <= 1'b0;
            s2_last  <= 1'b0;
            s2_mask  <= '0;
            s2_idx   <= '0;
        end else begin
            if (accept) begin
                idx_q  <= '0;
                len_q  <= issue_len;
                dst_q  <= issue_dst;
                srca_q <= issue_src_a;
                srcb_q <= issue_src_b;
                op_q   <= vop_e'(issue_op);
            end else if (state == ST_ISSUE) begin
                idx_q  <= idx_next;
            end
            s1_valid <= (state == ST_ISSUE);
            s1_last  <= last_issue;
            s1_mask  <= lane_live;
            s1_idx   <= idx_q;
            s2_valid <= s1_valid;
            s2_last  <= s1_last;
            s2_mask  <= s1_mask;
            s2_idx   <= s1_idx;
        end
    end

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(len_q) && $stable(dst_q) && $stable(op_q))) // R2
        else $error("instruction changed while busy");

    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && issue_len == '0) |=> (done && !busy && wr_en == '0)) // R9
        else $error("zero-length instruction misbehaved");

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done) // R8
        else $error("done missing after busy");

    AST_WR_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en != '0) |-> busy) // R8
        else $error("write outside busy window");

endmodule

// File: rtl/tsimd_vfu.sv
module tsimd_vfu
    import tsimd_vfu_pkg::*;
#(
    parameter int LANES  = 1,
    parameter int DW     = 16,
    parameter int FRAC_W = 12,
    parameter int AW     = 8,
    parameter int LEN_W  = 8,
    parameter int LUT_AW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_valid,
    input  logic [1:0]          issue_op,
    input  logic [AW-1:0]       issue_dst,
    input  logic [AW-1:0]       issue_src_a,
    input  logic [AW-1:0]       issue_src_b,
    input  logic [LEN_W-1:0]    issue_len,
    output logic                busy,
    output logic                done,
    output logic [LANES-1:0]    rd_en,
    output logic [LANES*AW-1:0] rd_a_addr,
    output logic [LANES*AW-1:0] rd_b_addr,
    input  logic [LANES*DW-1:0] rd_a_data,
    input  logic [LANES*DW-1:0] rd_b_data,
    output logic [LANES-1:0]    wr_en,
    output logic [LANES*AW-1:0] wr_addr,
    output logic [LANES*DW-1:0] wr_data
);
    localparam int ONE = 1 << FRAC_W;

    vop_e          op;
    logic [AW-1:0] rd_a_base, rd_b_base, wr_base;

    tsimd_vfu_seq #(
        .LANES(LANES),
        .AW   (AW),
        .LEN_W(LEN_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_valid(issue_valid),
        .issue_op   (issue_op),
        .issue_dst  (issue_dst),
        .issue_src_a(issue_src_a),
        .issue_src_b(issue_src_b),
        .issue_len  (issue_len),
        .busy       (busy),
        .done       (done),
        .op_o       (op),
        .rd_en      (rd_en),
        .rd_a_base  (rd_a_base),
        .rd_b_base  (rd_b_base),
        .wr_en      (wr_en),
        .wr_base    (wr_base)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign rd_a_addr[j*AW +: AW] = rd_a_base + AW'(j);
        assign rd_b_addr[j*AW +: AW] = rd_b_base + AW'(j);
        assign wr_addr[j*AW +: AW]   = wr_base + AW'(j);

        tsimd_vfu_lane #(
            .DW    (DW),
            .FRAC_W(FRAC_W),
            .LUT_AW(LUT_AW)
        ) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .op   (op),
            .a    (rd_a_data[j*DW +: DW]),
            .b    (rd_b_data[j*DW +: DW]),
            .res  (wr_data[j*DW +: DW])
        );
    end

    AST_WR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[0] && $past(wr_en[0])) |-> (wr_addr[AW-1:0] == $past(wr_addr[AW-1:0]) + AW'(LANES))) // R7
        else $error("write address not ascending");

    AST_SIG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[0] && op == OP_SIG) |->
            ($signed(wr_data[DW-1:0]) >= 0 && $signed(wr_data[DW-1:0]) <= ONE)) // R5
        else $error("sigmoid out of range");

    AST_TANH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[0] && op == OP_TANH) |->
            ($signed(wr_data[DW-1:0]) >= -ONE && $signed(wr_data[DW-1:0]) <= ONE)) // R6
        else $error("tanh out of range");

endmodule

// File: tb/tsimd_vfu_tb.sv
module tsimd_vfu_tb;
    localparam int LANES = 1;
    localparam int DW    = 16;
    localparam int AW    = 8;
    localparam int LEN_W = 8;
    localparam int NV    = 20;

    // {op, a, b, expected}
    localparam logic [49:0] VEC [NV] = '{
        {2'd0, 16'h1000, 16'h0800, 16'h1800},   // R3 1.0+0.5
        {2'd0, 16'h7000, 16'h2000, 16'h7FFF},   // R3 positive saturation
        {2'd0, 16'h9000, 16'h9000, 16'h8000},   // R3 negative saturation
        {2'd0, 16'hF000, 16'h0800, 16'hF800},   // R3 mixed sign
        {2'd1, 16'h2000, 16'h1800, 16'h3000},   // R4 2*1.5
        {2'd1, 16'h4000, 16'h4000, 16'h7FFF},   // R4 positive saturation
        {2'd1, 16'h4000, 16'hC000, 16'h8000},   // R4 negative saturation
        {2'd1, 16'hF800, 16'h0800, 16'hFC00},   // R4 -0.5*0.5
        {2'd1, 16'h0001, 16'hFFFF, 16'hFFFF},   // R4 floor rounding
        {2'd2, 16'h0000, 16'h7FFF, 16'h0800},   // R5 k=0
        {2'd2, 16'h0100, 16'h1234, 16'h0840},   // R5 k=1
        {2'd2, 16'h02FF, 16'h0000, 16'h0880},   // R5 low bits ignored
        {2'd2, 16'h4000, 16'h7FFF, 16'h1000},   // R5 upper clamp
        {2'd2, 16'hC000, 16'h7FFF, 16'h0000},   // R5 lower clamp
        {2'd2, 16'hFF00, 16'h8000, 16'h07C0},   // R5 k=-1
        {2'd3, 16'h0100, 16'h7FFF, 16'h0100},   // R6 k=1
        {2'd3, 16'h1500, 16'h0000, 16'h1000},   // R6 upper clamp
        {2'd3, 16'hF000, 16'h7FFF, 16'hF000},   // R6 k=-16
        {2'd3, 16'hE000, 16'h1111, 16'hF000},   // R6 lower clamp
        {2'd3, 16'hFF80, 16'h7FFF, 16'hFF00}    // R6 k=-1, low bits ignored
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                issue_valid = 1'b0;
    logic [1:0]          issue_op = 2'd0;
    logic [AW-1:0]       issue_dst = '0, issue_src_a = '0, issue_src_b = '0;
    logic [LEN_W-1:0]    issue_len = '0;
    logic                busy, done;
    logic [LANES-1:0]    rd_en, wr_en;
    logic [LANES*AW-1:0] rd_a_addr, rd_b_addr, wr_addr;
    logic [LANES*DW-1:0] rd_a_data = '0, rd_b_data = '0, wr_data;

    logic [DW-1:0] mem [256];
    logic          tb_we = 1'b0;
    logic [AW-1:0] tb_wa = '0;
    logic [DW-1:0] tb_wd = '0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    tsimd_vfu #(.LANES(LANES), .DW(DW), .AW(AW), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_op(issue_op), .issue_dst(issue_dst),
        .issue_src_a(issue_src_a), .issue_src_b(issue_src_b), .issue_len(issue_len),
        .busy(busy), .done(done),
        .rd_en(rd_en), .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // register file model: synchronous reads, writes from DUT and bench
    always @(posedge clk) begin
        if (rd_en[0]) begin
            rd_a_data <= mem[rd_a_addr];
            rd_b_data <= mem[rd_b_addr];
        end
        if (wr_en[0]) mem[wr_addr] <= wr_data;
        if (tb_we)    mem[tb_wa]   <= tb_wd;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [AW-1:0] ad, input logic [DW-1:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_wa = ad; tb_wd = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic issue(input logic [1:0] op, input logic [AW-1:0] dst,
                         input logic [AW-1:0] sa, input logic [AW-1:0] sb,
                         input logic [LEN_W-1:0] n);
        @(negedge clk);
        issue_valid = 1'b1; issue_op = op; issue_dst = dst;
        issue_src_a = sa; issue_src_b = sb; issue_len = n;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int guard = 0;
        while (!done && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        if (!done) check(req, 32'd0, 32'd1);
    endtask

    function automatic logic [DW-1:0] sat_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
        int s;
        s = int'($signed(a)) + int'($signed(b));
        if (s > 32767)  s = 32767;
        if (s < -32768) s = -32768;
        return DW'(s);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=hung expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // reset state
        check("R1 reset busy", 32'(busy), 32'd0);
        check("R8 reset done", 32'(done), 32'd0);
        check("R8 reset wr_en", 32'(wr_en), 32'd0);
        rst_n = 1'b1;

        // vector table, one element per instruction
        for (int v = 0; v < NV; v++) begin
            string tag;
            case (VEC[v][49:48])
                2'd0: tag = "R3 add";
                2'd1: tag = "R4 mul";
                2'd2: tag = "R5 sigmoid";
                default: tag = "R6 tanh";
            endcase
            poke(8'd10, VEC[v][47:32]);
            poke(8'd20, VEC[v][31:16]);
            issue(VEC[v][49:48], 8'd30, 8'd10, 8'd20, 8'd1);
            wait_done(tag);
            check(tag, 32'(mem[30]), 32'(VEC[v][15:0]));
        end

        // long add: ordering and busy length, n=20
        for (int i = 0; i < 20; i++) begin
            poke(AW'(60 + i), DW'(i * 16'h0600));
            poke(AW'(90 + i), 16'h1000);
        end
        begin
            int cnt = 0;
            int k = 0;
            issue(2'd0, 8'd130, 8'd60, 8'd90, 8'd20);
            check("R1 busy after accept", 32'(busy), 32'd1);
            while (busy && cnt < 100) begin
                if (wr_en[0]) begin
                    check("R7 write address", 32'(wr_addr), 32'(130 + k));
                    check("R3 long add data", 32'(wr_data),
                          32'(sat_add(DW'(k * 16'h0600), 16'h1000)));
                    k++;
                end
                cnt++;
                @(negedge clk);
            end
            check("R8 busy cycles", 32'(cnt), 32'd22);
            check("R8 done after busy", 32'(done), 32'd1);
            check("R7 write count", 32'(k), 32'd20);
            @(negedge clk);
            check("R8 done single pulse", 32'(done), 32'd0);
        end

        // refusal while busy
        for (int i = 0; i < 4; i++) poke(AW'(200 + i), 16'h1234);
        issue(2'd0, 8'd170, 8'd60, 8'd90, 8'd8);
        @(negedge clk);
        issue_valid = 1'b1; issue_op = 2'd1; issue_dst = 8'd200;
        issue_src_a = 8'd60; issue_src_b = 8'd90; issue_len = 8'd4;
        @(negedge clk);
        issue_valid = 1'b0;
        wait_done("R2 first completes");
        @(negedge clk);
        for (int i = 0; i < 4; i++)
            check("R2 ignored dest untouched", 32'(mem[200 + i]), 32'h1234);
        for (int i = 0; i < 8; i++)
            check("R2 running result", 32'(mem[170 + i]),
                  32'(sat_add(DW'(i * 16'h0600), 16'h1000)));
        check("R2 no late busy", 32'(busy), 32'd0);

        // zero length
        poke(8'd150, 16'h5555);
        issue(2'd0, 8'd150, 8'd60, 8'd90, 8'd0);
        check("R9 done at once", 32'(done), 32'd1);
        check("R9 busy low", 32'(busy), 32'd0);
        check("R9 no write", 32'(wr_en), 32'd0);
        @(negedge clk);
        check("R9 dest untouched", 32'(mem[150]), 32'h5555);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule